// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block is the control sequencer that runs a primitive string operation over and over under a repeat prefix. A request latches the operation kind, the prefix flavour, the address width and a starting count. The block then loops. Each pass first tests the count and stops at once if it is zero. If the count is not zero, the block opens an interrupt window, starts one primitive through a start/done handshake, and takes one off the count. For compare and scan primitives it then tests the zero flag returned with the primitive.

The primitive datapath, the memory traffic and the interrupt service live outside the block and appear only as handshakes. When the loop ends, the block pulses a completion strobe. It also shows why the loop ended (count used up, zero-flag condition no longer met, or illegal prefix use) and the final count value for write-back. A repeat request for an operation that is not a string primitive is refused at once with an invalid-opcode indication.

With a narrow address size, only the low half of the count register counts and the upper half passes through untouched. With a wide address size, the whole register counts.

Top module: `strrep_seq`

## Requirements
- R1: With `addr_wide`=1 the full CNT_W-bit count is decremented and tested for zero; with `addr_wide`=0 only the low NARROW_W bits are decremented and tested.
- R2: If the count under test is zero when a pass begins, the run ends with `exit_cause`=2'b00 (count exhausted) and no `prim_start`. For a zero count at request time, `done` is high in the second cycle after the edge that samples `go`.
- R3: When `irq_pend` is high at the start of a pass with a non-zero count, `irq_ack` rises and stays high until `irq_done` is seen. The primitive starts only after that, and never in a cycle with `irq_ack` high.
- R4: Every completed primitive (`prim_done` after `prim_start`) lowers the count by exactly one. The number of `prim_start` pulses of a run that ends by count equals the starting count, and `cnt_out` holds the final count when `done` is high.
- R5: Operation codes are 0 move, 1 store, 2 port input, 3 port output, 4 compare, 5 scan. Only codes 4 and 5 test `zf_in`; for codes 0 to 3, `zf_in` and `rep_ne` have no effect on the run.
- R6: For compare/scan, `rep_ne`=0 ends the run when the returned zero flag is 0, and `rep_ne`=1 ends it when the flag is 1, with `exit_cause`=2'b01. This test is made after the decrement and before the next zero-count test.
- R7: With `addr_wide`=0, bits CNT_W-1..NARROW_W of the count keep their loaded value throughout the run and at `cnt_out`.
- R8: Operation codes 6 and 7 are not string primitives. A request with them gives `done` and `ud_fault` high in the first cycle after the sampling edge, with `exit_cause`=2'b10, no `prim_start`, and `cnt_out` equal to `cnt_in`.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after the request until `done` falls. A `go` while busy is ignored.
- R10: After reset, `busy`, `done`, `prim_start`, `irq_ack` and `ud_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Request a repeated run (taken when idle) |
| op_kind | input | 3 | Primitive operation code |
| rep_ne | input | 1 | 0: repeat while equal, 1: repeat while not equal |
| addr_wide | input | 1 | 1: full-width count, 0: narrow count |
| cnt_in | input | CNT_W | Starting count register value |
| irq_pend | input | 1 | An interrupt is waiting for service |
| irq_ack | output | 1 | Interrupt window open, service requested |
| irq_done | input | 1 | Interrupt service finished |
| prim_start | output | 1 | One-cycle start of one primitive |
| prim_done | input | 1 | Primitive finished, `zf_in` valid |
| zf_in | input | 1 | Zero flag returned by the primitive |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| exit_cause | output | 2 | 00 count, 01 condition, 10 illegal |
| ud_fault | output | 1 | Invalid-opcode indication, with `done` |
| cnt_out | output | CNT_W | Current and final count value |

## Verification
The illegal-operation result is due in the first cycle after the edge that samples `go`, and the zero-count result in the second. The bench counts whole cycles from that edge and samples on the falling edge, so it catches a result that comes one state early or late. A pass without an interrupt takes three cycles: test, start, then wait for `prim_done`. The bench's primitive model returns `prim_done` exactly one cycle after the `prim_start` it sees, and its interrupt model holds `irq_done` off for two cycles of `irq_ack`. The counts of starts and acknowledges, the final count and the exit cause are compared at the `done` cycle against values worked out from the starting count and the scripted zero flags.

// File: rtl/strrep_pkg.sv
package strrep_pkg;

   localparam int OPC_W = 3;

   localparam logic [OPC_W-1:0] OPC_MOVE  = 3'd0;
   localparam logic [OPC_W-1:0] OPC_STORE = 3'd1;
   localparam logic [OPC_W-1:0] OPC_PIN   = 3'd2;
   localparam logic [OPC_W-1:0] OPC_POUT  = 3'd3;
   localparam logic [OPC_W-1:0] OPC_CMP   = 3'd4;
   localparam logic [OPC_W-1:0] OPC_SCAN  = 3'd5;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_TEST  = 3'd1,
      SQ_INTR  = 3'd2,
      SQ_FIRE  = 3'd3,
      SQ_WAIT  = 3'd4,
      SQ_FIN   = 3'd5
   } seq_st_t;

   typedef enum logic [1:0] {
      XC_COUNT   = 2'b00,
      XC_COND    = 2'b01,
      XC_ILLEGAL = 2'b10
   } xcause_t;

   function automatic logic opc_is_string(input logic [OPC_W-1:0] opc);
      return (opc <= OPC_SCAN);
   endfunction

   function automatic logic opc_tests_zf(input logic [OPC_W-1:0] opc);
      return (opc == OPC_CMP) || (opc == OPC_SCAN);
   endfunction

endpackage

// File: rtl/strrep_count.sv
module strrep_count #(
   parameter int CNT_W    = 32,
   parameter int NARROW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   input  logic             wide,
   output logic [CNT_W-1:0] cnt,
   output logic             is_zero
);

   localparam int UPPER_W = CNT_W - NARROW_W;

   generate
      if (NARROW_W < 1 || NARROW_W >= CNT_W) begin : g_bad_width
         $error("strrep_count: NARROW_W must lie in 1..CNT_W-1");
      end
   endgenerate

   logic [CNT_W-1:0]    nxt;
   logic [NARROW_W-1:0] low_dec;

   assign low_dec = cnt[NARROW_W-1:0] - {{(NARROW_W-1){1'b0}}, 1'b1};

   always_comb begin
      nxt = cnt;
      if (load) begin
         nxt = load_val;
      end else if (dec) begin
         if (wide) begin
            nxt = cnt - {{(CNT_W-1){1'b0}}, 1'b1};
         end else begin
            nxt[NARROW_W-1:0] = low_dec;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end

   assign is_zero = wide ? (cnt == '0) : (cnt[NARROW_W-1:0] == '0);

   // R7: narrow decrements leave the upper part alone
   a_r7_upper_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !wide) |=> (cnt[CNT_W-1:NARROW_W] == $past(cnt[CNT_W-1:NARROW_W])))
      else $error("a_r7_upper_kept");

   // R4: a decrement moves the low part down by exactly one
   a_r4_low_step : assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |=> (cnt[NARROW_W-1:0] == $past(cnt[NARROW_W-1:0]) - {{(NARROW_W-1){1'b0}}, 1'b1}))
      else $error("a_r4_low_step");

   logic unused_upper;
   assign unused_upper = (UPPER_W > 0);

endmodule

// File: rtl/strrep_cond.sv
module strrep_cond
   import strrep_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   input  logic             rep_ne,
   input  logic             zf,
   output logic             tests_zf,
   output logic             stop
);

   assign tests_zf = opc_tests_zf(opc);

   // repeat-while-equal stops on a clear flag, repeat-while-not-equal on a set one
   always_comb begin
      stop = 1'b0;
      if (tests_zf) begin
         if (rep_ne) stop = zf;
         else        stop = ~zf;
      end
   end

endmodule

// File: rtl/strrep_ctrl.sv
module strrep_ctrl
   import strrep_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      go,
   input  logic      legal,
   input  logic      cnt_zero,
   input  logic      irq_pend,
   input  logic      irq_done,
   input  logic      prim_done,
   input  logic      stop,
   output logic      load,
   output logic      dec,
   output logic      busy,
   output logic      done,
   output logic      irq_ack,
   output logic      prim_start,
   output xcause_t   cause
);

   seq_st_t st, st_n;
   xcause_t cause_n;

   always_comb begin
      st_n    = st;
      cause_n = cause;
      case (st)
         SQ_IDLE: begin
            if (go) begin
               if (legal) begin
                  st_n = SQ_TEST;
               end else begin
                  st_n    = SQ_FIN;
                  cause_n = XC_ILLEGAL;
               end
            end
         end
         SQ_TEST: begin
            if (cnt_zero) begin
               st_n    = SQ_FIN;
               cause_n = XC_COUNT;
            end else if (irq_pend) begin
               st_n = SQ_INTR;
            end else begin
               st_n = SQ_FIRE;
            end
         end
         SQ_INTR: begin
            if (irq_done) st_n = SQ_FIRE;
         end
         SQ_FIRE: st_n = SQ_WAIT;
         SQ_WAIT: begin
            if (prim_done) begin
               if (stop) begin
                  st_n    = SQ_FIN;
                  cause_n = XC_COND;
               end else begin
                  st_n = SQ_TEST;
               end
            end
         end
         SQ_FIN:  st_n = SQ_IDLE;
         default: st_n = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SQ_IDLE;
         cause <= XC_COUNT;
      end else begin
         st    <= st_n;
         cause <= cause_n;
      end
   end

   assign load       = (st == SQ_IDLE) && go;
   assign dec        = (st == SQ_WAIT) && prim_done;
   assign busy       = (st != SQ_IDLE);
   assign done       = (st == SQ_FIN);
   assign irq_ack    = (st == SQ_INTR);
   assign prim_start = (st == SQ_FIRE);

   // R9: the end strobe lasts one cycle
   a_r9_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("a_r9_done_pulse");

   // R3: a finished interrupt service is followed straight by the primitive
   a_r3_ack_then_start : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_done) |=> prim_start)
      else $error("a_r3_ack_then_start");

   // R6: a failed zero-flag test closes the run with the condition cause
   a_r6_cond_exit : assert property (@(posedge clk) disable iff (!rst_n)
      (dec && stop) |=> (done && cause == XC_COND))
      else $error("a_r6_cond_exit");

   // R8: an illegal request ends in the next cycle
   a_r8_illegal_fast : assert property (@(posedge clk) disable iff (!rst_n)
      (load && !legal) |=> (done && cause == XC_ILLEGAL))
      else $error("a_r8_illegal_fast");

endmodule

// File: rtl/strrep_seq.sv
module strrep_seq
   import strrep_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int NARROW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [2:0]       op_kind,
   input  logic             rep_ne,
   input  logic             addr_wide,
   input  logic [CNT_W-1:0] cnt_in,
   input  logic             irq_pend,
   output logic             irq_ack,
   input  logic             irq_done,
   output logic             prim_start,
   input  logic             prim_done,
   input  logic             zf_in,
   output logic             busy,
   output logic             done,
   output logic [1:0]       exit_cause,
   output logic             ud_fault,
   output logic [CNT_W-1:0] cnt_out
);

   generate
      if (CNT_W > 64) begin : g_bad_cnt
         $error("strrep_seq: CNT_W above 64 is not supported");
      end
   endgenerate

   logic [OPC_W-1:0] opc_q;
   logic             ne_q;
   logic             wide_q;
   logic             load, dec, cnt_zero, stop, tests_zf, legal;
   xcause_t          cause;

   assign legal = opc_is_string(op_kind);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opc_q  <= OPC_MOVE;
         ne_q   <= 1'b0;
         wide_q <= 1'b1;
      end else if (load) begin
         opc_q  <= op_kind;
         ne_q   <= rep_ne;
         wide_q <= addr_wide;
      end
   end

   strrep_count #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (cnt_in),
      .dec      (dec),
      .wide     (wide_q),
      .cnt      (cnt_out),
      .is_zero  (cnt_zero)
   );

   strrep_cond u_cond (
      .opc      (opc_q),
      .rep_ne   (ne_q),
      .zf       (zf_in),
      .tests_zf (tests_zf),
      .stop     (stop)
   );

   strrep_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .legal      (legal),
      .cnt_zero   (cnt_zero),
      .irq_pend   (irq_pend),
      .irq_done   (irq_done),
      .prim_done  (prim_done),
      .stop       (stop),
      .load       (load),
      .dec        (dec),
      .busy       (busy),
      .done       (done),
      .irq_ack    (irq_ack),
      .prim_start (prim_start),
      .cause      (cause)
   );

   assign exit_cause = cause;
   assign ud_fault   = done && (cause == XC_ILLEGAL);

   // R4: a primitive never starts with the count already at zero
   a_r4_start_nonzero : assert property (@(posedge clk) disable iff (!rst_n)
      prim_start |-> !cnt_zero)
      else $error("a_r4_start_nonzero");

   // R2: a count-exhausted finish shows a zero count
   a_r2_count_exit_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (done && exit_cause == XC_COUNT) |-> cnt_zero)
      else $error("a_r2_count_exit_zero");

   // R3: the interrupt window and the primitive start never overlap
   a_r3_no_overlap : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_ack, prim_start, done}))
      else $error("a_r3_no_overlap");

   // R5: the zero flag only steers compare and scan runs
   a_r5_flag_scope : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tests_zf) |-> !stop)
      else $error("a_r5_flag_scope");

endmodule

// File: tb/sim_strrep_seq.sv
module sim_strrep_seq;
   import strrep_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [2:0]  op_kind = 3'd0;
   logic        rep_ne = 1'b0;
   logic        addr_wide = 1'b1;
   logic [31:0] cnt_in = '0;
   logic        irq_pend = 1'b0;
   logic        irq_ack;
   logic        irq_done = 1'b0;
   logic        prim_start;
   logic        prim_done = 1'b0;
   logic        zf_in = 1'b0;
   logic        busy, done, ud_fault;
   logic [1:0]  exit_cause;
   logic [31:0] cnt_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   strrep_seq u0 (
      .clk(clk), .rst_n(rst_n), .go(go), .op_kind(op_kind), .rep_ne(rep_ne),
      .addr_wide(addr_wide), .cnt_in(cnt_in), .irq_pend(irq_pend), .irq_ack(irq_ack),
      .irq_done(irq_done), .prim_start(prim_start), .prim_done(prim_done),
      .zf_in(zf_in), .busy(busy), .done(done), .exit_cause(exit_cause),
      .ud_fault(ud_fault), .cnt_out(cnt_out)
   );

   // primitive and interrupt models, updated away from the active edge
   logic zf_seq [0:15];
   int   nprim = 0;
   int   nack = 0;
   int   overlap = 0;
   logic pend = 1'b0;
   int   ack_cyc = 0;

   always @(negedge clk) begin
      prim_done = 1'b0;
      if (pend) begin
         prim_done = 1'b1;
         zf_in     = zf_seq[(nprim - 1) & 15];
         pend      = 1'b0;
      end
      if (prim_start) begin
         nprim = nprim + 1;
         pend  = 1'b1;
      end
      if (prim_start && irq_ack) overlap = overlap + 1;
      if (irq_ack) begin
         if (ack_cyc == 0) nack = nack + 1;
         ack_cyc  = ack_cyc + 1;
         irq_done = (ack_cyc >= 2);
      end else begin
         ack_cyc  = 0;
         irq_done = 1'b0;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // issues one request and returns the cycle, counted from the sampling edge, in which done was seen
   task automatic run(input logic [2:0] op, input logic ne, input logic wide,
                      input logic [31:0] c, input logic poke, output int cyc);
      @(negedge clk);
      nprim = 0; nack = 0; overlap = 0;
      op_kind = op; rep_ne = ne; addr_wide = wide; cnt_in = c; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      cyc = 1;
      while (!done && cyc < 3000) begin
         if (poke && cyc == 3) begin
            cnt_in = 32'h0000_0001; op_kind = 3'd7; go = 1'b1;
         end else begin
            go = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      go = 1'b0;
      if (!done) chk("R9", "done never seen", 32'd0, 32'd1);
   endtask

   task automatic t_reset();
      chk("R10", "busy after reset", busy, 0);
      chk("R10", "done after reset", done, 0);
      chk("R10", "prim_start after reset", prim_start, 0);
      chk("R10", "irq_ack after reset", irq_ack, 0);
      chk("R10", "ud_fault after reset", ud_fault, 0);
   endtask

   task automatic t_wide_move();
      int cyc;
      run(3'd0, 1'b0, 1'b1, 32'd5, 1'b0, cyc);
      chk("R4", "wide move starts", nprim, 5);
      chk("R4", "wide move final count", cnt_out, 0);
      chk("R1", "wide move cause", exit_cause, 2'b00);
      chk("R9", "busy during done", busy, 1);
      @(negedge clk);
      chk("R9", "done one cycle", done, 0);
   endtask

   task automatic t_narrow();
      int cyc;
      run(3'd1, 1'b0, 1'b0, 32'hABCD_0003, 1'b0, cyc);
      chk("R1", "narrow starts", nprim, 3);
      chk("R7", "narrow upper kept", cnt_out, 32'hABCD_0000);
      run(3'd2, 1'b0, 1'b0, 32'h0001_0000, 1'b0, cyc);
      chk("R2", "narrow zero low, no starts", nprim, 0);
      chk("R2", "narrow zero latency", cyc, 2);
      chk("R7", "narrow zero count out", cnt_out, 32'h0001_0000);
      chk("R2", "narrow zero cause", exit_cause, 2'b00);
   endtask

   task automatic t_zero_wide();
      int cyc;
      run(3'd4, 1'b1, 1'b1, 32'd0, 1'b0, cyc);
      chk("R2", "zero count latency", cyc, 2);
      chk("R2", "zero count starts", nprim, 0);
   endtask

   task automatic t_repe();
      int cyc;
      zf_seq[0] = 1; zf_seq[1] = 1; zf_seq[2] = 0;
      run(3'd4, 1'b0, 1'b1, 32'd10, 1'b0, cyc);
      chk("R6", "while-equal starts", nprim, 3);
      chk("R6", "while-equal count", cnt_out, 7);
      chk("R6", "while-equal cause", exit_cause, 2'b01);
   endtask

   task automatic t_repne();
      int cyc;
      zf_seq[0] = 0; zf_seq[1] = 0; zf_seq[2] = 0; zf_seq[3] = 1;
      run(3'd5, 1'b1, 1'b1, 32'd10, 1'b0, cyc);
      chk("R6", "while-not-equal starts", nprim, 4);
      chk("R6", "while-not-equal count", cnt_out, 6);
      chk("R6", "while-not-equal cause", exit_cause, 2'b01);
   endtask

   task automatic t_order();
      int cyc;
      zf_seq[0] = 0;
      run(3'd4, 1'b0, 1'b1, 32'd1, 1'b0, cyc);
      chk("R6", "last pass fails condition", exit_cause, 2'b01);
      chk("R6", "last pass count", cnt_out, 0);
      zf_seq[0] = 1; zf_seq[1] = 1;
      run(3'd4, 1'b0, 1'b1, 32'd2, 1'b0, cyc);
      chk("R6", "condition holds to end", exit_cause, 2'b00);
      chk("R6", "condition holds starts", nprim, 2);
   endtask

   task automatic t_flag_ignored();
      int cyc;
      for (int i = 0; i < 16; i++) zf_seq[i] = 0;
      run(3'd1, 1'b0, 1'b1, 32'd4, 1'b0, cyc);
      chk("R5", "store ignores clear flag", nprim, 4);
      chk("R5", "store cause", exit_cause, 2'b00);
      for (int i = 0; i < 16; i++) zf_seq[i] = 1;
      run(3'd3, 1'b1, 1'b1, 32'd3, 1'b0, cyc);
      chk("R5", "port output ignores set flag", nprim, 3);
      chk("R5", "port output count", cnt_out, 0);
   endtask

   task automatic t_irq();
      int cyc;
      irq_pend = 1'b1;
      run(3'd0, 1'b0, 1'b1, 32'd3, 1'b0, cyc);
      irq_pend = 1'b0;
      chk("R3", "windows taken", nack, 3);
      chk("R3", "starts with interrupts", nprim, 3);
      chk("R3", "start during window", overlap, 0);
      chk("R3", "count with interrupts", cnt_out, 0);
   endtask

   task automatic t_illegal();
      int cyc;
      run(3'd6, 1'b0, 1'b1, 32'h1234_5678, 1'b0, cyc);
      chk("R8", "illegal latency", cyc, 1);
      chk("R8", "illegal fault", ud_fault, 1);
      chk("R8", "illegal cause", exit_cause, 2'b10);
      chk("R8", "illegal starts", nprim, 0);
      chk("R8", "illegal count out", cnt_out, 32'h1234_5678);
      @(negedge clk);
      chk("R8", "fault clears", ud_fault, 0);
   endtask

   task automatic t_busy_go();
      int cyc;
      run(3'd0, 1'b0, 1'b1, 32'd4, 1'b1, cyc);
      chk("R9", "go while busy ignored starts", nprim, 4);
      chk("R9", "go while busy no fault", ud_fault, 0);
      chk("R9", "go while busy count", cnt_out, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) zf_seq[i] = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wide_move();
      t_narrow();
      t_zero_wide();
      t_repe();
      t_repne();
      t_order();
      t_flag_ignored();
      t_irq();
      t_illegal();
      t_busy_go();
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule